// File: doc/BRIEF.md
# Branch Target Buffer with Multi-Target Indirect Entries

This block is a set-associative prediction cache indexed by the fetch address. A lookup is answered in the same cycle. If the address matches a stored branch, the block returns whether the branch is predicted taken. It also returns the address to fetch next, so the fetch stage can redirect without decoding the instruction. A miss predicts fall-through to the next sequential word.

Branches resolved later in the pipeline are written back through an update port. That port carries the branch kind, the outcome, a byte offset and an actual target. For a relative branch, the target is formed at update time as branch address plus offset, and only the sum is stored. An indirect branch may hold several ways of its set, each with a different target. Each set keeps a small history register that records the way of the most recent correct indirect target, and the lookup prefers that way.

Top module: `btb_multi_target`

## Requirements
- R1: After reset, every lookup misses. It predicts not taken and returns the lookup address plus 4.
- R2: A lookup that matches no valid entry gives hit=0, taken=0 and target = lookup address + 4.
- R3: A taken update for a relative branch (`up_indirect`=0) that has no entry allocates one. The entry holds target = `up_pc` + `up_offset` and direction counter 2. A later lookup of that address therefore hits, predicts taken and returns that target.
- R4: An update with `up_taken`=0 for a branch that has no entry allocates nothing, and later lookups of that address still miss.
- R5: Each entry has a 2-bit counter that saturates at 0 and at 3. A taken update raises it by one and a not-taken update lowers it by one. A hit predicts taken only when the counter is 2 or 3, and otherwise returns the lookup address + 4.
- R6: The set index is PC bits [5:2] (16 sets) and the tag is PC bits [31:6]. An address with the same index but a different tag misses.
- R7: A taken indirect update (`up_indirect`=1) whose `up_target` matches no entry of that branch allocates a new way with counter 2. The set history then points at that way, and the next lookup returns the new target.
- R8: An indirect update whose target matches an existing way of that branch moves the set history to that way. The next lookup returns that target, and no new way is allocated.
- R9: Each set allocates ways in round-robin order, 0,1,2,3 and then 0 again. Allocation overwrites the old contents of the chosen way.
- R10: If an update and a lookup arrive in the same cycle, the lookup returns the contents from before the update. The update becomes visible in the following cycle.
- R11: When the set history points at a way that does not belong to the looked-up indirect branch, the lookup uses the lowest-numbered way that matches the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_pc | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_taken | output | 1 | Branch predicted taken |
| lk_target | output | 32 | Predicted next fetch address |
| up_valid | input | 1 | Resolved branch update present this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_indirect | input | 1 | 1 = indirect branch, 0 = relative branch |
| up_taken | input | 1 | Resolved outcome |
| up_offset | input | 32 | Byte offset of a relative branch, sign-extended |
| up_target | input | 32 | Actual target of an indirect branch |

## Verification
The lookup path has no registers, so each lookup result is compared two time units after the falling edge on which the address is driven. This is the same half cycle, before the next rising edge. An update is applied on the rising edge after it is driven. Its effect is first expected on a lookup driven at the following falling edge, and a lookup issued together with the update is expected to show the earlier contents. The driver queues each expected result when it drives the address, and the monitor pops and compares the queue at that fixed offset. A result therefore can never be matched against a stimulus from a different cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

  localparam logic [1:0] CTR_WEAK_TAKEN = 2'd2;

  // saturating 2-bit direction counter step
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (cur == 2'd3) ? cur : cur + 2'd1;
    else    nxt = (cur == 2'd0) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int PC_W  = 32,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int IDX_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS),
  parameter int TAG_W = PC_W - 2 - IDX_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  // read port A (lookup)
  input  logic [IDX_W-1:0]              ra_set,
  output logic [WAYS-1:0]               ra_vld,
  output logic [WAYS-1:0]               ra_ind,
  output logic [WAYS-1:0][TAG_W-1:0]    ra_tag,
  output logic [WAYS-1:0][1:0]          ra_ctr,
  output logic [WAYS-1:0][PC_W-1:0]     ra_tgt,
  output logic [WAY_W-1:0]              ra_hist,
  // read port B (update)
  input  logic [IDX_W-1:0]              rb_set,
  output logic [WAYS-1:0]               rb_vld,
  output logic [WAYS-1:0]               rb_ind,
  output logic [WAYS-1:0][TAG_W-1:0]    rb_tag,
  output logic [WAYS-1:0][1:0]          rb_ctr,
  output logic [WAYS-1:0][PC_W-1:0]     rb_tgt,
  output logic [WAY_W-1:0]              rb_rr,
  // write port
  input  logic                          wr_en,
  input  logic                          wr_alloc,
  input  logic [IDX_W-1:0]              wr_set,
  input  logic [WAY_W-1:0]              wr_way,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic                          wr_ind,
  input  logic [1:0]                    wr_ctr,
  input  logic [PC_W-1:0]               wr_tgt,
  input  logic                          rr_adv,
  input  logic                          hist_wr,
  input  logic [WAY_W-1:0]              hist_val
);

  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q, vld_d;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             ind_q [SETS];
    logic [1:0]       ctr_q [SETS];
    logic [PC_W-1:0]  tgt_q [SETS];
    logic             way_we;

    assign way_we = wr_en && (wr_way == WAY_W'(w));

    always_comb begin
      vld_d = vld_q;
      if (way_we) vld_d[wr_set] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (way_we) begin
        tag_q[wr_set] <= wr_tag;
        ind_q[wr_set] <= wr_ind;
        ctr_q[wr_set] <= wr_ctr;
        tgt_q[wr_set] <= wr_tgt;
      end
    end

    assign ra_vld[w] = vld_q[ra_set];
    assign ra_ind[w] = ind_q[ra_set];
    assign ra_tag[w] = tag_q[ra_set];
    assign ra_ctr[w] = ctr_q[ra_set];
    assign ra_tgt[w] = tgt_q[ra_set];
    assign rb_vld[w] = vld_q[rb_set];
    assign rb_ind[w] = ind_q[rb_set];
    assign rb_tag[w] = tag_q[rb_set];
    assign rb_ctr[w] = ctr_q[rb_set];
    assign rb_tgt[w] = tgt_q[rb_set];

    // R3
    weak_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_alloc && wr_way == WAY_W'(w)) |=>
        (vld_q[$past(wr_set)] && ctr_q[$past(wr_set)] == btb_pkg::CTR_WEAK_TAKEN));
  end

  logic [WAY_W-1:0] rr_q [SETS];
  logic [WAY_W-1:0] rr_d [SETS];
  logic [WAY_W-1:0] hist_q [SETS];
  logic [WAY_W-1:0] hist_d [SETS];

  always_comb begin
    rr_d = rr_q;
    if (rr_adv) rr_d[wr_set] = (rr_q[wr_set] == LAST_WAY) ? '0 : rr_q[wr_set] + 1'b1;
  end

  always_comb begin
    hist_d = hist_q;
    if (hist_wr) hist_d[wr_set] = hist_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s]   <= '0;
        hist_q[s] <= '0;
      end
    end else begin
      rr_q   <= rr_d;
      hist_q <= hist_d;
    end
  end

  assign ra_hist = hist_q[ra_set];
  assign rb_rr   = rr_q[rb_set];

  // R9
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rr_adv |=> (rr_q[$past(wr_set)] ==
               (($past(rr_q[wr_set]) == LAST_WAY) ? '0 : $past(rr_q[wr_set]) + 1'b1)));

  // R7
  hist_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist_wr |=> (hist_q[$past(wr_set)] == $past(hist_val)));

endmodule

// File: rtl/btb_sel.sv
module btb_sel #(
  parameter int PC_W  = 32,
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS),
  parameter int TAG_W = 26
) (
  input  logic [TAG_W-1:0]           pc_tag,
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0]            ind,
  input  logic [WAYS-1:0][TAG_W-1:0] tag,
  input  logic [WAYS-1:0][1:0]       ctr,
  input  logic [WAYS-1:0][PC_W-1:0]  tgt,
  input  logic [WAY_W-1:0]           hist,
  output logic                       hit,
  output logic [1:0]                 sel_ctr,
  output logic [PC_W-1:0]            sel_tgt
);

  logic [WAYS-1:0]  match;
  logic [WAY_W-1:0] low_way;
  logic [WAY_W-1:0] use_way;
  logic             hist_ok;

  always_comb begin
    for (int w = 0; w < WAYS; w++) match[w] = vld[w] && (tag[w] == pc_tag);
    low_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) low_way = WAY_W'(w);
    end
    // history is trusted only when it names an indirect way of this branch
    hist_ok = match[hist] && ind[hist];
    use_way = hist_ok ? hist : low_way;
    hit     = |match;
    sel_ctr = ctr[use_way];
    sel_tgt = tgt[use_way];
  end

endmodule

// File: rtl/btb_upd.sv
module btb_upd #(
  parameter int PC_W  = 32,
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS),
  parameter int TAG_W = 26
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       up_valid,
  input  logic                       up_ind,
  input  logic                       up_taken,
  input  logic [TAG_W-1:0]           up_tag,
  input  logic [PC_W-1:0]            up_pc,
  input  logic [PC_W-1:0]            up_off,
  input  logic [PC_W-1:0]            up_tgt,
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0]            ind,
  input  logic [WAYS-1:0][TAG_W-1:0] tag,
  input  logic [WAYS-1:0][1:0]       ctr,
  input  logic [WAYS-1:0][PC_W-1:0]  tgt,
  input  logic [WAY_W-1:0]           rr,
  output logic                       wr_en,
  output logic                       wr_alloc,
  output logic [WAY_W-1:0]           wr_way,
  output logic [1:0]                 wr_ctr,
  output logic [PC_W-1:0]            wr_tgt,
  output logic                       rr_adv,
  output logic                       hist_wr,
  output logic [WAY_W-1:0]           hist_val
);

  logic [PC_W-1:0]  res_tgt;
  logic [WAYS-1:0]  match;
  logic [WAY_W-1:0] hit_way;

  always_comb begin
    res_tgt = up_ind ? up_tgt : (up_pc + up_off);
    for (int w = 0; w < WAYS; w++) begin
      match[w] = vld[w] && (tag[w] == up_tag) && (ind[w] == up_ind) &&
                 (!up_ind || (tgt[w] == res_tgt));
    end
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  always_comb begin
    wr_en    = 1'b0;
    wr_alloc = 1'b0;
    wr_way   = hit_way;
    wr_ctr   = ctr[hit_way];
    wr_tgt   = tgt[hit_way];
    rr_adv   = 1'b0;
    hist_wr  = 1'b0;
    hist_val = hit_way;
    if (up_valid) begin
      if (|match) begin
        wr_en   = 1'b1;
        wr_ctr  = btb_pkg::ctr_step(ctr[hit_way], up_taken);
        wr_tgt  = up_taken ? res_tgt : tgt[hit_way];
        hist_wr = up_ind;
      end else if (up_taken) begin
        wr_en    = 1'b1;
        wr_alloc = 1'b1;
        wr_way   = rr;
        wr_ctr   = btb_pkg::CTR_WEAK_TAKEN;
        wr_tgt   = res_tgt;
        rr_adv   = 1'b1;
        hist_wr  = up_ind;
        hist_val = rr;
      end
    end
  end

  // R4
  nt_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken) |-> !wr_alloc);

  // R9
  alloc_uses_rr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_alloc |-> (wr_way == rr && rr_adv));

endmodule

// File: rtl/btb_multi_target.sv
module btb_multi_target #(
  parameter int PC_W = 32,
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [31:0]     lk_target,
  input  logic            up_valid,
  input  logic [31:0]     up_pc,
  input  logic            up_indirect,
  input  logic            up_taken,
  input  logic [31:0]     up_offset,
  input  logic [31:0]     up_target
);

  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = PC_W - 2 - IDX_W;
  localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(4);

  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [IDX_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  assign lk_set = lk_pc[2 +: IDX_W];
  assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
  assign up_set = up_pc[2 +: IDX_W];
  assign up_tag = up_pc[PC_W-1 -: TAG_W];

  logic [WAYS-1:0]            ra_vld, ra_ind, rb_vld, rb_ind;
  logic [WAYS-1:0][TAG_W-1:0] ra_tag, rb_tag;
  logic [WAYS-1:0][1:0]       ra_ctr, rb_ctr;
  logic [WAYS-1:0][PC_W-1:0]  ra_tgt, rb_tgt;
  logic [WAY_W-1:0]           ra_hist, rb_rr;

  logic             wr_en, wr_alloc, rr_adv, hist_wr;
  logic [WAY_W-1:0] wr_way, hist_val;
  logic [1:0]       wr_ctr;
  logic [PC_W-1:0]  wr_tgt;

  btb_store #(.PC_W(PC_W), .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W),
              .WAY_W(WAY_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_sync_q),
    .ra_set(lk_set), .ra_vld(ra_vld), .ra_ind(ra_ind), .ra_tag(ra_tag),
    .ra_ctr(ra_ctr), .ra_tgt(ra_tgt), .ra_hist(ra_hist),
    .rb_set(up_set), .rb_vld(rb_vld), .rb_ind(rb_ind), .rb_tag(rb_tag),
    .rb_ctr(rb_ctr), .rb_tgt(rb_tgt), .rb_rr(rb_rr),
    .wr_en(wr_en), .wr_alloc(wr_alloc), .wr_set(up_set), .wr_way(wr_way),
    .wr_tag(up_tag), .wr_ind(up_indirect), .wr_ctr(wr_ctr), .wr_tgt(wr_tgt),
    .rr_adv(rr_adv), .hist_wr(hist_wr), .hist_val(hist_val)
  );

  logic [1:0]      sel_ctr;
  logic [PC_W-1:0] sel_tgt;

  btb_sel #(.PC_W(PC_W), .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_sel (
    .pc_tag(lk_tag), .vld(ra_vld), .ind(ra_ind), .tag(ra_tag), .ctr(ra_ctr),
    .tgt(ra_tgt), .hist(ra_hist), .hit(lk_hit), .sel_ctr(sel_ctr), .sel_tgt(sel_tgt)
  );

  btb_upd #(.PC_W(PC_W), .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_upd (
    .clk(clk), .rst_n(rst_sync_q),
    .up_valid(up_valid && rst_sync_q), .up_ind(up_indirect), .up_taken(up_taken),
    .up_tag(up_tag), .up_pc(up_pc), .up_off(up_offset), .up_tgt(up_target),
    .vld(rb_vld), .ind(rb_ind), .tag(rb_tag), .ctr(rb_ctr), .tgt(rb_tgt), .rr(rb_rr),
    .wr_en(wr_en), .wr_alloc(wr_alloc), .wr_way(wr_way), .wr_ctr(wr_ctr),
    .wr_tgt(wr_tgt), .rr_adv(rr_adv), .hist_wr(hist_wr), .hist_val(hist_val)
  );

  always_comb begin
    lk_taken  = lk_hit && sel_ctr[1];
    lk_target = lk_taken ? sel_tgt : (lk_pc + SEQ_STEP);
  end

  // R2
  miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !lk_hit |-> (!lk_taken && lk_target == lk_pc + SEQ_STEP));

endmodule

// File: tb/sim_btb_multi_target.sv
module sim_btb_multi_target;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        lk_hit, lk_taken;
  logic [31:0] lk_target;
  logic        up_valid;
  logic [31:0] up_pc;
  logic        up_indirect, up_taken;
  logic [31:0] up_offset, up_target;

  always #5 clk = ~clk;

  btb_multi_target u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_target(lk_target), .up_valid(up_valid), .up_pc(up_pc),
    .up_indirect(up_indirect), .up_taken(up_taken), .up_offset(up_offset),
    .up_target(up_target)
  );

  typedef struct {
    logic        hit;
    logic        taken;
    logic [31:0] target;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  // monitor: compares the combinational lookup result before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (lk_hit !== e.hit || lk_taken !== e.taken || lk_target !== e.target) begin
          errors++;
          $display("FAIL %s: got hit=%0b taken=%0b target=%h, expected hit=%0b taken=%0b target=%h",
                   e.req, lk_hit, lk_taken, lk_target, e.hit, e.taken, e.target);
        end
      end
    end
  end

  task automatic push(input logic h, input logic t, input logic [31:0] tg, input string req);
    exp_t e;
    e.hit = h; e.taken = t; e.target = tg; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic look(input logic [31:0] pc, input logic h, input logic t,
                      input logic [31:0] tg, input string req);
    @(negedge clk);
    lk_pc = pc;
    push(h, t, tg, req);
  endtask

  task automatic drive_upd(input logic [31:0] pc, input logic ind, input logic tk,
                           input logic [31:0] off, input logic [31:0] tgt);
    up_valid = 1'b1; up_pc = pc; up_indirect = ind; up_taken = tk;
    up_offset = off; up_target = tgt;
  endtask

  task automatic upd(input logic [31:0] pc, input logic ind, input logic tk,
                     input logic [31:0] off, input logic [31:0] tgt);
    @(negedge clk);
    drive_upd(pc, ind, tk, off, tgt);
    @(posedge clk);
    #1 up_valid = 1'b0;
  endtask

  localparam logic [31:0] PA = 32'h0000_1004;  // set 1
  localparam logic [31:0] PB = 32'h0000_301C;  // set 7
  localparam logic [31:0] PC_ = 32'h0000_4008; // set 2, indirect
  localparam logic [31:0] PD = 32'h0000_5008;  // set 2, indirect
  localparam logic [31:0] PE = 32'h0000_6008;  // set 2, direct
  localparam logic [31:0] PF = 32'h0000_7008;  // set 2, direct

  initial begin
    rst_n = 1'b0; lk_pc = '0; up_valid = 1'b0; up_pc = '0; up_indirect = 1'b0;
    up_taken = 1'b0; up_offset = '0; up_target = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    look(32'h0000_100C, 1'b0, 1'b0, 32'h0000_1010, "R1 reset miss set3");
    look(PA,            1'b0, 1'b0, PA + 4,        "R1 reset miss set1");

    // R4 not-taken on absent branch allocates nothing
    upd(PA, 1'b0, 1'b0, 32'h40, '0);
    look(PA, 1'b0, 1'b0, PA + 4, "R4 no allocation");

    // R3 taken relative branch allocates weakly taken with pc+offset
    upd(PA, 1'b0, 1'b1, 32'h40, '0);
    look(PA, 1'b1, 1'b1, 32'h0000_1044, "R3 allocated target");

    // R6 same index different tag misses; R2 miss output
    look(32'h0000_2004, 1'b0, 1'b0, 32'h0000_2008, "R6 tag mismatch");
    look(32'h0000_1008, 1'b0, 1'b0, 32'h0000_100C, "R2 other set miss");

    // R5 counter walk 2 -> 1 -> 0 -> 0 -> 1 -> 2 -> 3 -> 3 -> 2
    upd(PA, 1'b0, 1'b0, 32'h40, '0);
    look(PA, 1'b1, 1'b0, PA + 4, "R5 ctr1 not taken");
    upd(PA, 1'b0, 1'b0, 32'h40, '0);
    upd(PA, 1'b0, 1'b0, 32'h40, '0);
    upd(PA, 1'b0, 1'b1, 32'h40, '0);
    look(PA, 1'b1, 1'b0, PA + 4, "R5 floor saturation");
    upd(PA, 1'b0, 1'b1, 32'h40, '0);
    look(PA, 1'b1, 1'b1, 32'h0000_1044, "R5 ctr2 taken");
    upd(PA, 1'b0, 1'b1, 32'h40, '0);
    upd(PA, 1'b0, 1'b1, 32'h40, '0);
    upd(PA, 1'b0, 1'b0, 32'h40, '0);
    look(PA, 1'b1, 1'b1, 32'h0000_1044, "R5 ceiling saturation");

    // R10 same-cycle update and lookup: old contents first
    @(negedge clk);
    drive_upd(PB, 1'b0, 1'b1, 32'hFFFF_FFF8, '0);
    lk_pc = PB;
    push(1'b0, 1'b0, PB + 4, "R10 pre-update lookup");
    @(posedge clk);
    #1 up_valid = 1'b0;
    look(PB, 1'b1, 1'b1, 32'h0000_3014, "R10 post-update lookup");

    // R7 indirect allocation of distinct targets
    upd(PC_, 1'b1, 1'b1, '0, 32'h0000_9000);
    look(PC_, 1'b1, 1'b1, 32'h0000_9000, "R7 first indirect target");
    upd(PC_, 1'b1, 1'b1, '0, 32'h0000_A000);
    look(PC_, 1'b1, 1'b1, 32'h0000_A000, "R7 second indirect target");

    // R8 returning to an earlier target re-selects its way
    upd(PC_, 1'b1, 1'b1, '0, 32'h0000_9000);
    look(PC_, 1'b1, 1'b1, 32'h0000_9000, "R8 reselect old target");
    upd(PC_, 1'b1, 1'b1, '0, 32'h0000_A000);
    look(PC_, 1'b1, 1'b1, 32'h0000_A000, "R8 reselect newer target");

    // R11 history taken by another branch: lowest matching way used
    upd(PD, 1'b1, 1'b1, '0, 32'h0000_B000);
    look(PD, 1'b1, 1'b1, 32'h0000_B000, "R7 other indirect branch");
    look(PC_, 1'b1, 1'b1, 32'h0000_9000, "R11 fallback lowest way");

    // R9 round robin: way3 then wrap to way0 (evicts first indirect target)
    upd(PE, 1'b0, 1'b1, 32'h100, '0);
    upd(PF, 1'b0, 1'b1, 32'h200, '0);
    look(PF, 1'b1, 1'b1, 32'h0000_7208, "R9 wrap allocation");
    look(PE, 1'b1, 1'b1, 32'h0000_6108, "R9 way3 kept");
    look(PC_, 1'b1, 1'b1, 32'h0000_A000, "R9 way0 evicted");
    look(PD, 1'b1, 1'b1, 32'h0000_B000, "R9 way2 kept");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule